// File: doc/BRIEF.md
# Nibble-Serial Operand Loader for a Half-Precision Arithmetic Unit

This block is the pin-limited front end of a 16-bit floating-point unit. A 12-bit input bus brings in two 16-bit operands four bits at a time. Each cycle carries one nibble of each operand, side by side, and the least significant nibble comes first. A load-enable bit marks the cycles that carry data, and an operation-select bit picks addition or multiplication. Once the last nibble is in, the block hands both operands to the external arithmetic datapath and pulses a start strobe. It then waits for that datapath to report completion.

The 16-bit result goes back on a 12-bit output bus as two bytes, low byte first, with a valid flag that covers both cycles. A rising edge on the load enable begins a new transaction at any point and abandons whatever was in progress. The adder and multiplier datapaths are separate blocks. This block covers only the loading, the launch and the return sequencing.

Top module: `fpu_nibble_wrap`

## Requirements
- R1: While reset (active high) is asserted and just after it is released, every bit of `io_out` and `fpu_start` is 0.
- R2: On each load cycle, operand A's nibble is read from `io_in[3:0]` and operand B's nibble from `io_in[7:4]`. The first load cycle fills bits 3:0 of each operand, the next fills 7:4, then 11:8, then 15:12. `fpu_a` and `fpu_b` show the assembled operands when `fpu_start` is high.
- R3: `io_in[8]` selects the operation (1 = add, 0 = multiply). It is latched in the first load cycle of a transaction. `fpu_add` keeps that value even if `io_in[8]` changes later in the transaction.
- R4: `fpu_start` goes high for exactly one cycle. That cycle immediately follows the clock edge that captures the fourth nibble.
- R5: When `io_in[9]` stays high after the fourth nibble, the extra cycles capture nothing and launch no second operation. The operands remain as loaded.
- R6: In the cycle after the clock edge at which `fpu_done` is seen while waiting, `io_out[7:0]` carries result bits 7:0 and `io_out[8]` is 1. In the cycle after that, `io_out[7:0]` carries bits 15:8 and `io_out[8]` is still 1. After that, `io_out[8]` returns to 0.
- R7: A rising edge on `io_in[9]` (low in the previous cycle, high now) starts a new transaction. That cycle's nibbles become nibble 0, the nibble counter restarts, and `io_out[8]` is 0 from the next cycle onward.
- R8: `io_out[11:9]` is always 0, and `io_out[7:0]` is 0 whenever `io_out[8]` is 0.
- R9: `fpu_done` has no effect unless an operation has been launched and has not yet completed. The output bus stays all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| io_in | input | 12 | Nibble of A [3:0], nibble of B [7:4], op select [8], load enable [9], [11:10] unused |
| io_out | output | 12 | Result byte [7:0], result valid [8], [11:9] always 0 |
| fpu_a | output | 16 | Assembled operand A to the arithmetic datapath |
| fpu_b | output | 16 | Assembled operand B to the arithmetic datapath |
| fpu_add | output | 1 | Latched select: 1 = add, 0 = multiply |
| fpu_start | output | 1 | One-cycle launch strobe |
| fpu_result | input | 16 | Result from the datapath, sampled with `fpu_done` |
| fpu_done | input | 1 | Datapath completion strobe |

## Verification
The bench targets these failure modes:
- **Nibble ordering and lane swaps.** It uses operands whose nibbles all differ, so a reversed order or swapped A/B lanes shows up as wrong `fpu_a`/`fpu_b` values.
- **Late select changes.** It flips the select bit after the first load cycle. A design that samples the select late would launch the wrong operation.
- **Enable held too long.** It keeps the enable high past the fourth nibble. A counter that wraps instead of saturating would corrupt operand A and fire a second start.
- **Restarts and stray completions.** It restarts mid-load and mid-output, and it pulses `fpu_done` while idle. A design that kept stale nibbles, went on sending bytes, or sent an unrequested result would be caught there.

// File: rtl/fpw_pkg.sv
package fpw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_START,
      ST_WAIT,
      ST_SEND
   } fpw_state_e;

endpackage

// File: rtl/fpw_loader.sv
module fpw_loader #(
   parameter int NIB_W = 4,
   parameter int OP_W  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              restart,
   input  logic              load_en,
   input  logic [NIB_W-1:0]  nib_a,
   input  logic [NIB_W-1:0]  nib_b,
   output logic [OP_W-1:0]   op_a,
   output logic [OP_W-1:0]   op_b,
   output logic              last_nib
);
   localparam int NIBBLES = OP_W / NIB_W;
   localparam int CNT_W   = $clog2(NIBBLES + 1);

   logic [CNT_W-1:0] cnt_q;
   logic             take;

   assign take = load_en && !restart && (cnt_q < CNT_W'(NIBBLES));

   always_ff @(posedge clk) begin
      if (rst)          cnt_q <= '0;
      else if (restart) cnt_q <= CNT_W'(1);
      else if (take)    cnt_q <= cnt_q + CNT_W'(1);
   end

   generate
      if (NIBBLES == 1) begin : g_single
         assign last_nib = restart || take;
      end else begin : g_multi
         assign last_nib = take && (cnt_q == CNT_W'(NIBBLES - 1));
      end

      for (genvar k = 0; k < NIBBLES; k++) begin : g_slot
         logic [NIB_W-1:0] sa_q;
         logic [NIB_W-1:0] sb_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               sa_q <= '0;
               sb_q <= '0;
            end else if (restart) begin
               sa_q <= (k == 0) ? nib_a : '0;
               sb_q <= (k == 0) ? nib_b : '0;
            end else if (take && cnt_q == CNT_W'(k)) begin
               sa_q <= nib_a;
               sb_q <= nib_b;
            end
         end
         assign op_a[k*NIB_W +: NIB_W] = sa_q;
         assign op_b[k*NIB_W +: NIB_W] = sb_q;
      end
   endgenerate
endmodule

// File: rtl/fpw_seq.sv
module fpw_seq
   import fpw_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       restart,
   input  logic       last_nib,
   input  logic       fpu_done,
   input  logic       send_last,
   output fpw_state_e state,
   output logic       start,
   output logic       grab
);
   fpw_state_e state_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
      end else if (restart) begin
         state_q <= last_nib ? ST_START : ST_LOAD;
      end else begin
         unique case (state_q)
            ST_IDLE:  state_q <= ST_IDLE;
            ST_LOAD:  if (last_nib) state_q <= ST_START;
            ST_START: state_q <= ST_WAIT;
            ST_WAIT:  if (fpu_done) state_q <= ST_SEND;
            ST_SEND:  if (send_last) state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign state = state_q;
   assign start = (state_q == ST_START);
   assign grab  = (state_q == ST_WAIT) && fpu_done && !restart;
endmodule

// File: rtl/fpw_ser.sv
module fpw_ser #(
   parameter int OP_W  = 16,
   parameter int OUT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             grab,
   input  logic [OP_W-1:0]  result_in,
   input  logic             active,
   output logic [OUT_W-1:0] beat_data,
   output logic             beat_valid,
   output logic             beat_last
);
   localparam int BEATS  = OP_W / OUT_W;
   localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

   logic [OP_W-1:0]   res_q;
   logic [BEAT_W-1:0] beat_q;
   logic [OUT_W-1:0]  lane [BEATS];

   always_ff @(posedge clk) begin
      if (rst) begin
         res_q  <= '0;
         beat_q <= '0;
      end else if (grab) begin
         res_q  <= result_in;
         beat_q <= '0;
      end else if (active) begin
         beat_q <= beat_q + BEAT_W'(1);
      end
   end

   generate
      for (genvar j = 0; j < BEATS; j++) begin : g_lane
         assign lane[j] = res_q[j*OUT_W +: OUT_W];
      end
   endgenerate

   assign beat_valid = active;
   assign beat_data  = active ? lane[beat_q] : '0;
   assign beat_last  = active && (beat_q == BEAT_W'(BEATS - 1));
endmodule

// File: rtl/fpu_nibble_wrap.sv
module fpu_nibble_wrap
   import fpw_pkg::*;
#(
   parameter int NIB_W = 4,
   parameter int OP_W  = 16,
   parameter int OUT_W = 8,
   parameter int BUS_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [BUS_W-1:0] io_in,
   output logic [BUS_W-1:0] io_out,
   output logic [OP_W-1:0]  fpu_a,
   output logic [OP_W-1:0]  fpu_b,
   output logic             fpu_add,
   output logic             fpu_start,
   input  logic [OP_W-1:0]  fpu_result,
   input  logic             fpu_done
);
   localparam int SEL_BIT   = 2 * NIB_W;
   localparam int EN_BIT    = 2 * NIB_W + 1;
   localparam int VALID_BIT = OUT_W;

   generate
      if (OP_W % NIB_W != 0) begin : g_bad_nib
         $error("operand width must be a whole number of nibbles");
      end
      if (OP_W % OUT_W != 0) begin : g_bad_out
         $error("operand width must be a whole number of output beats");
      end
      if (BUS_W < EN_BIT + 1 || BUS_W < VALID_BIT + 1) begin : g_bad_bus
         $error("bus too narrow for lanes and control bits");
      end
   endgenerate

   logic       en_prev_q;
   logic       load_en;
   logic       restart;
   logic       add_q;
   logic       last_nib;
   logic       start;
   logic       grab;
   logic       send_last;
   logic       beat_valid;
   logic [OUT_W-1:0] beat_data;
   fpw_state_e state;

   assign load_en = io_in[EN_BIT];
   assign restart = load_en && !en_prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         en_prev_q <= 1'b0;
         add_q     <= 1'b0;
      end else begin
         en_prev_q <= load_en;
         if (restart) add_q <= io_in[SEL_BIT];
      end
   end

   fpw_loader #(.NIB_W(NIB_W), .OP_W(OP_W)) u_loader (
      .clk      (clk),
      .rst      (rst),
      .restart  (restart),
      .load_en  (load_en),
      .nib_a    (io_in[NIB_W-1:0]),
      .nib_b    (io_in[2*NIB_W-1:NIB_W]),
      .op_a     (fpu_a),
      .op_b     (fpu_b),
      .last_nib (last_nib)
   );

   fpw_seq u_seq (
      .clk       (clk),
      .rst       (rst),
      .restart   (restart),
      .last_nib  (last_nib),
      .fpu_done  (fpu_done),
      .send_last (send_last),
      .state     (state),
      .start     (start),
      .grab      (grab)
   );

   fpw_ser #(.OP_W(OP_W), .OUT_W(OUT_W)) u_ser (
      .clk        (clk),
      .rst        (rst),
      .grab       (grab),
      .result_in  (fpu_result),
      .active     (state == ST_SEND),
      .beat_data  (beat_data),
      .beat_valid (beat_valid),
      .beat_last  (send_last)
   );

   assign fpu_add   = add_q;
   assign fpu_start = start;

   always_comb begin
      io_out                  = '0;
      io_out[OUT_W-1:0]       = beat_data;
      io_out[VALID_BIT]       = beat_valid;
   end
endmodule

// File: rtl/fpw_checker.sv
module fpw_checker #(
   parameter int NIB_W = 4,
   parameter int OUT_W = 8,
   parameter int BUS_W = 12
) (
   input logic             clk,
   input logic             rst,
   input logic [BUS_W-1:0] io_in,
   input logic [BUS_W-1:0] io_out,
   input logic             fpu_start
);
   localparam int EN_BIT = 2 * NIB_W + 1;

   logic v;
   logic en;
   assign v  = io_out[OUT_W];
   assign en = io_in[EN_BIT];

   assert_spare_low_R8: assert property (@(posedge clk) disable iff (rst)
      (io_out >> (OUT_W + 1)) == '0);

   assert_byte_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      !v |-> io_out[OUT_W-1:0] == '0);

   assert_start_single_R4: assert property (@(posedge clk) disable iff (rst)
      fpu_start |=> !fpu_start);

   assert_valid_pair_R6: assert property (@(posedge clk) disable iff (rst)
      ($rose(v) && !(en && !$past(en))) |=> v);

   assert_restart_drop_R7: assert property (@(posedge clk) disable iff (rst)
      (en && !$past(en)) |=> !v);
endmodule

bind fpu_nibble_wrap fpw_checker #(.NIB_W(NIB_W), .OUT_W(OUT_W), .BUS_W(BUS_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .io_in     (io_in),
   .io_out    (io_out),
   .fpu_start (fpu_start)
);

// File: tb/fpu_nibble_wrap_tb.sv
`timescale 1ns/1ps
module fpu_nibble_wrap_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en  = 1'b0;
   logic        sel = 1'b0;
   logic [3:0]  na  = '0;
   logic [3:0]  nb  = '0;
   logic [11:0] io_in;
   logic [11:0] io_out;
   logic [15:0] fpu_a, fpu_b, fpu_result = '0;
   logic        fpu_add, fpu_start;
   logic        fpu_done = 1'b0;
   int total = 0;
   int bad   = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   assign io_in = {2'b00, en, sel, nb, na};

   fpu_nibble_wrap u_dut (
      .clk(clk), .rst(rst), .io_in(io_in), .io_out(io_out),
      .fpu_a(fpu_a), .fpu_b(fpu_b), .fpu_add(fpu_add), .fpu_start(fpu_start),
      .fpu_result(fpu_result), .fpu_done(fpu_done)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         bad++; total++;
         $display("FAIL watchdog act=%0d exp=<20000", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // drive four paired nibbles; sel may flip after the first; extra high cycles after
   task automatic load(input logic [15:0] a, input logic [15:0] b, input logic s,
                       input logic flip, input int extra);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         en = 1'b1;
         sel = (k > 0 && flip) ? ~s : s;
         na = a[k*4 +: 4];
         nb = b[k*4 +: 4];
      end
      @(negedge clk);
      check("R4 start after fourth nibble", fpu_start, 1'b1);
      check("R2 operand A", fpu_a, a);
      check("R2 operand B", fpu_b, b);
      check("R3 latched select", fpu_add, s);
      na = 4'hF; nb = 4'hF;
      for (int e = 0; e < extra; e++) begin
         @(negedge clk);
         check("R5 no second start", fpu_start, 1'b0);
      end
      en = 1'b0;
   endtask

   task automatic give_result(input logic [15:0] r);
      @(negedge clk);
      check("R4 start one cycle", fpu_start, 1'b0);
      fpu_done = 1'b1; fpu_result = r;
      @(negedge clk);
      fpu_done = 1'b0; fpu_result = 16'h0000;
      check("R6 low byte", io_out, {3'b000, 1'b1, r[7:0]});
      @(negedge clk);
      check("R6 high byte", io_out, {3'b000, 1'b1, r[15:8]});
      @(negedge clk);
      check("R8 quiet after send", io_out, 12'h000);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 io_out in reset", io_out, 12'h000);
      check("R1 start in reset", fpu_start, 1'b0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 io_out after reset", io_out, 12'h000);
   endtask

   task automatic t_add();
      load(16'h4A3C, 16'h3155, 1'b1, 1'b0, 0);
      give_result(16'hBE71);
   endtask

   task automatic t_mul_flip();
      load(16'h9E28, 16'h07D6, 1'b0, 1'b1, 0);
      check("R3 flip ignored", fpu_add, 1'b0);
      give_result(16'h5A0C);
   endtask

   task automatic t_extra();
      load(16'h1234, 16'hABCD, 1'b1, 1'b0, 3);
      check("R5 operand A held", fpu_a, 16'h1234);
      check("R5 operand B held", fpu_b, 16'hABCD);
      fpu_done = 1'b1; fpu_result = 16'hC3E1;
      @(negedge clk);
      fpu_done = 1'b0;
      check("R6 low byte after extra", io_out, 12'h1E1);
      @(negedge clk);
      check("R6 high byte after extra", io_out, 12'h1C3);
      @(negedge clk);
   endtask

   task automatic t_stray_done();
      @(negedge clk);
      fpu_done = 1'b1; fpu_result = 16'hDEAD;
      @(negedge clk);
      fpu_done = 1'b0;
      check("R9 stray done ignored", io_out, 12'h000);
      @(negedge clk);
      check("R9 stray done ignored later", io_out, 12'h000);
   endtask

   task automatic t_restart_load();
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         en = 1'b1; sel = 1'b1; na = 4'h7; nb = 4'h8;
      end
      @(negedge clk);
      en = 1'b0;
      check("R7 no start on partial", fpu_start, 1'b0);
      load(16'h6B05, 16'hF2E9, 1'b0, 1'b0, 0);
      give_result(16'h0F3A);
   endtask

   task automatic t_restart_send();
      load(16'h2468, 16'h1357, 1'b1, 1'b0, 0);
      @(negedge clk);
      fpu_done = 1'b1; fpu_result = 16'h77AA;
      @(negedge clk);
      fpu_done = 1'b0;
      check("R6 low byte before restart", io_out, 12'h1AA);
      en = 1'b1; sel = 1'b0; na = 4'h1; nb = 4'h9;
      @(negedge clk);
      check("R7 valid dropped", io_out, 12'h000);
      na = 4'h2; nb = 4'hA;
      @(negedge clk);
      na = 4'h3; nb = 4'hB;
      @(negedge clk);
      na = 4'h4; nb = 4'hC;
      @(negedge clk);
      en = 1'b0;
      check("R7 restart start", fpu_start, 1'b1);
      check("R7 restart operand A", fpu_a, 16'h4321);
      check("R7 restart operand B", fpu_b, 16'hCBA9);
      check("R7 restart select", fpu_add, 1'b0);
      give_result(16'h3C01);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      t_add();
      t_mul_flip();
      t_extra();
      t_stray_done();
      t_restart_load();
      t_restart_send();
      repeat (3) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule